// File: doc/BRIEF.md
# Carrier Cycle and Phase Measurement Latch

This block runs a carrier numerically controlled oscillator and counts its positive-going zero crossings. The oscillator is a phase accumulator that adds a programmable frequency word on every clock. Each carry out of its most significant bit is one positive-going zero crossing, and a crossing counter counts these carries.

On every measurement epoch strobe, the block takes a snapshot of two values in the same clock cycle: the crossing count, and the top bits of the accumulator as a fractional phase. The counter then starts a new interval at once. Software reads the snapshot through a small register read port, one word per read, and adds up the per-epoch counts itself to get the integrated carrier phase. The snapshot does not change between strobes, so software may read the fields in any order.

Top module: `carr_meas_latch`

## Requirements
- R1: On every clock out of reset, the 32-bit phase accumulator adds `freq_word_i` modulo 2^32. The phase field is the top 10 accumulator bits, so one phase LSB equals 2π/1024 radians.
- R2: A positive-going zero crossing is a carry out of the accumulator's most significant bit. Between strobes, the crossing counter rises by exactly one for each crossing and is otherwise unchanged.
- R3: A clock with `epoch_i` high latches two values: the count held before that clock, and the phase field held before that clock (before the accumulator update of that clock).
- R4: In the strobe clock the counter restarts. After that clock it reads 1 if a crossing happened in that clock and 0 if not, so no crossing is lost or counted twice.
- R5: The latched count is one more than the number of complete carrier cycles in the interval. A cycle runs from one crossing to the next.
- R6: The counter is 20 bits wide (a CNT_W parameter). It wraps modulo 2^CNT_W and does not saturate.
- R7: Register read map: address 0 gives the top 4 bits of the latched count, zero-extended. Address 1 gives the remaining low bits (16 at defaults). Address 2 gives the 10-bit phase, zero-extended. Address 3 reads zero. Data and `rd_valid_o` appear one clock after a clock with `rd_en_i` high. `rd_valid_o` is low otherwise.
- R8: The latched count and phase change only on a strobe. Reads in any order between two strobes return fields of one snapshot.
- R9: After reset the accumulator, counter, snapshot, `rd_data_o` and `rd_valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word_i | input | 32 | Phase increment per clock |
| epoch_i | input | 1 | Measurement epoch strobe, one clock wide |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 2 | Read word select |
| rd_data_o | output | 16 | Read data, one clock after request |
| rd_valid_o | output | 1 | Read data valid |

## Verification
The bench sweeps the strobe across every offset of a 16-clock crossing period, so one strobe lands in the same clock as a crossing. A design that latched after the increment, or cleared the counter to zero, would then count that crossing twice or drop it. Back-to-back strobes must give counts of 0 or 1; a counter that failed to restart would instead keep growing. A narrow counter instance is run past 2^12 crossings to show the wrap, where a saturating counter would stick at all ones. Reads in reverse order, and reads while the frequency word changes without a strobe, show that the snapshot stays coherent and held.

// File: rtl/carr_meas_pkg.sv
package carr_meas_pkg;
    typedef enum logic [1:0] {
        SEL_CNT_HI = 2'd0,
        SEL_CNT_LO = 2'd1,
        SEL_PHASE  = 2'd2,
        SEL_RSVD   = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/cnco_acc.sv
module cnco_acc #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] fw_i,
    output logic [ACC_W-1:0] acc_o,
    output logic [PH_W-1:0]  phase_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum        = {1'b0, st_q.acc} + {1'b0, fw_i};
        st_d.acc   = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o   = st_q.acc;
    assign phase_o = st_q.acc[ACC_W-1 -: PH_W];
    assign wrap_o  = sum[ACC_W];
endmodule

// File: rtl/xing_counter.sv
module xing_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic             epoch_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        if (epoch_i) st_d.cnt = CNT_W'(wrap_i);
        else         st_d.cnt = st_q.cnt + CNT_W'(wrap_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/meas_snap.sv
module meas_snap
    import carr_meas_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int HI_W   = 4,
    parameter int PH_W   = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              epoch_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [PH_W-1:0]   phase_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic [CNT_W-1:0]  snap_cnt_o,
    output logic [PH_W-1:0]   snap_ph_o
);
    localparam int LO_W = CNT_W - HI_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PH_W-1:0]   ph;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] word;

    always_comb begin
        word = '0;
        case (rd_sel_e'(rd_addr_i))
            SEL_CNT_HI: word[HI_W-1:0] = st_q.cnt[CNT_W-1 -: HI_W];
            SEL_CNT_LO: word[LO_W-1:0] = st_q.cnt[LO_W-1:0];
            SEL_PHASE:  word[PH_W-1:0] = st_q.ph;
            default:    word = '0;
        endcase

        st_d        = st_q;
        st_d.rvalid = rd_en_i;
        st_d.rdata  = rd_en_i ? word : '0;
        if (epoch_i) begin
            st_d.cnt = cnt_i;
            st_d.ph  = phase_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o  = st_q.rdata;
    assign rd_valid_o = st_q.rvalid;
    assign snap_cnt_o = st_q.cnt;
    assign snap_ph_o  = st_q.ph;
endmodule

// File: rtl/carr_meas_latch.sv
module carr_meas_latch #(
    parameter int ACC_W  = 32,
    parameter int PH_W   = 10,
    parameter int CNT_W  = 20,
    parameter int HI_W   = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  freq_word_i,
    input  logic              epoch_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    logic [ACC_W-1:0] acc_w;
    logic [PH_W-1:0]  phase_w;
    logic             wrap_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] snap_cnt_w;
    logic [PH_W-1:0]  snap_ph_w;

    cnco_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .fw_i(freq_word_i),
        .acc_o(acc_w), .phase_o(phase_w), .wrap_o(wrap_w)
    );

    xing_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap_w),
        .epoch_i(epoch_i), .cnt_o(cnt_w)
    );

    meas_snap #(.CNT_W(CNT_W), .HI_W(HI_W), .PH_W(PH_W), .DATA_W(DATA_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .epoch_i(epoch_i),
        .cnt_i(cnt_w), .phase_i(phase_w),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
        .snap_cnt_o(snap_cnt_w), .snap_ph_o(snap_ph_w)
    );
endmodule

// File: rtl/carr_meas_chk.sv
module carr_meas_chk #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10,
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] fw,
    input logic             epoch,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [ACC_W-1:0] acc,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] snap_cnt,
    input logic [PH_W-1:0]  snap_ph
);
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> acc == $past(acc) + $past(fw)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))); // R2
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        epoch |=> cnt <= CNT_W'(1)); // R4
    AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        epoch |=> snap_cnt == $past(cnt)); // R3
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch |=> $stable(snap_cnt) && $stable(snap_ph)); // R8
    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R7
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R7
endmodule

bind carr_meas_latch carr_meas_chk #(.ACC_W(ACC_W), .PH_W(PH_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fw(freq_word_i), .epoch(epoch_i),
    .rd_en(rd_en_i), .rd_valid(rd_valid_o), .acc(acc_w), .cnt(cnt_w),
    .snap_cnt(snap_cnt_w), .snap_ph(snap_ph_w)
);

// File: tb/carr_meas_latch_tb_top.sv
module carr_meas_ref #(
    parameter int CW = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] fw,
    input  logic        epoch,
    output logic [19:0] snap_cnt,
    output logic [9:0]  snap_ph
);
    localparam logic [19:0] MASK = 20'((64'd1 << CW) - 1);
    logic [31:0] acc;
    logic [19:0] cnt;
    logic [32:0] s;
    assign s = {1'b0, acc} + {1'b0, fw};
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0; cnt <= '0; snap_cnt <= '0; snap_ph <= '0;
        end else begin
            acc <= s[31:0];
            cnt <= epoch ? {19'd0, s[32]} : ((cnt + {19'd0, s[32]}) & MASK);
            if (epoch) begin
                snap_cnt <= cnt;
                snap_ph  <= acc[31:22];
            end
        end
    end
endmodule

module carr_meas_latch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fw = '0;
    logic        epoch = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data_a, rd_data_b;
    logic        rd_valid_a, rd_valid_b;
    logic [19:0] m_cnt_a, m_cnt_b;
    logic [9:0]  m_ph_a, m_ph_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  addr;
        logic [15:0] exp_a;
        logic [15:0] exp_b;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    carr_meas_latch dut_i (
        .clk(clk), .rst_n(rst_n), .freq_word_i(fw), .epoch_i(epoch),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data_a), .rd_valid_o(rd_valid_a)
    );
    carr_meas_latch #(.CNT_W(12)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .freq_word_i(fw), .epoch_i(epoch),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data_b), .rd_valid_o(rd_valid_b)
    );
    carr_meas_ref #(.CW(20)) ref_a (.clk(clk), .rst_n(rst_n), .fw(fw), .epoch(epoch),
                                    .snap_cnt(m_cnt_a), .snap_ph(m_ph_a));
    carr_meas_ref #(.CW(12)) ref_b (.clk(clk), .rst_n(rst_n), .fw(fw), .epoch(epoch),
                                    .snap_cnt(m_cnt_b), .snap_ph(m_ph_b));

    function automatic logic [15:0] exp_word(input logic [1:0] a, input logic [19:0] c,
                                             input logic [9:0] p, input int cw);
        case (a)
            2'd0:    return 16'(c >> (cw - 4));
            2'd1:    return 16'(c & 20'((64'd1 << (cw - 4)) - 1));
            2'd2:    return {6'd0, p};
            default: return 16'd0;
        endcase
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_epoch();
        epoch = 1'b1;
        @(negedge clk);
        epoch = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        item_t it;
        it.addr  = a;
        it.exp_a = exp_word(a, m_cnt_a, m_ph_a, 20);
        it.exp_b = exp_word(a, m_cnt_b, m_ph_b, 12);
        it.tag   = tag;
        sb_q.push_back(it);
        rd_en   = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en   = 1'b0;
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && rd_valid_a) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data: actual %h expected none", rd_data_a);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                checks += 2;
                if (rd_data_a !== it.exp_a) begin
                    errors++;
                    $display("FAIL %s addr %0d main: actual %h expected %h",
                             it.tag, it.addr, rd_data_a, it.exp_a);
                end
                if (!rd_valid_b || rd_data_b !== it.exp_b) begin
                    errors++;
                    $display("FAIL %s addr %0d narrow: actual %h expected %h",
                             it.tag, it.addr, rd_data_b, it.exp_b);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        checks++;
        if (rd_valid_a !== 1'b0 || rd_data_a !== 16'd0) begin
            errors++;
            $display("FAIL R9 reset outputs: actual %b/%h expected 0/0000", rd_valid_a, rd_data_a);
        end
        rst_n = 1'b1;
        tick(1);
        // R9 and R7: reset snapshot and full read map
        for (int a = 0; a < 4; a++) rd(2'(a), "R9 reset snapshot");

        // R2 R3 R5: crossing every 16 clocks
        fw = 32'h1000_0000;
        tick(50);
        pulse_epoch();
        rd(2'd0, "R2 count high");
        rd(2'd1, "R5 count low");
        rd(2'd2, "R3 phase");

        // R4: strobe at every offset of a crossing period, incl. a crossing clock
        for (int off = 0; off < 17; off++) begin
            tick(off);
            pulse_epoch();
            rd(2'd1, "R4 sweep count");
            rd(2'd2, "R3 sweep phase");
        end

        // R4: back-to-back strobes
        epoch = 1'b1;
        tick(2);
        epoch = 1'b0;
        rd(2'd1, "R4 back-to-back");

        // R1 R8: odd word, reads in reverse order
        fw = 32'h0123_4567;
        tick(300);
        pulse_epoch();
        rd(2'd2, "R1 odd phase");
        rd(2'd1, "R8 reverse low");
        rd(2'd0, "R8 reverse high");

        // R8: word changes without a strobe, snapshot held
        fw = 32'h7FFF_FFFF;
        tick(40);
        rd(2'd1, "R8 held low");
        rd(2'd2, "R8 held phase");
        rd(2'd3, "R7 reserved");

        // R6: narrow instance wraps
        fw = 32'hFFFF_FFFF;
        pulse_epoch();
        tick(4200);
        pulse_epoch();
        rd(2'd0, "R6 wrap high");
        rd(2'd1, "R6 wrap low");

        // R1: phase LSB step
        fw = 32'h0040_0000;
        tick(700);
        pulse_epoch();
        rd(2'd2, "R1 lsb phase");
        rd(2'd1, "R5 slow count");

        tick(4);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R7 reads outstanding: actual %0d expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule